// File: doc/BRIEF.md
# Tamper Input Event Detector

This block watches one external tamper pin and turns a configured event on it into a latched tamper flag. The pin is first brought into the clock domain through a chain of flip-flops. The block then evaluates it in one of two modes. If the filter field is zero, the block looks for a single edge, and the polarity bit picks which edge. If the filter field is nonzero, the block looks for an active level that must hold for a number of consecutive samples. Samples are taken only on an external sample strobe, and the polarity bit picks which level counts as active.

Software sets the configuration through a write strobe that loads every field at once. It clears the flag by writing zero to it. The interrupt request is the flag gated by the interrupt enable. An optional setting makes each tamper event also emit a one-cycle pulse that sets the timestamp flag, whether or not timestamping is switched on elsewhere. Configuration is meant to change only while detection is disabled. Re-enabling after a change never produces a false event.

Top module: `tamper_detect_top`

## Requirements
- R1: With `cfg_filt` = 0 (edge mode), `cfg_pol` = 0 makes a low-to-high pin transition an event and `cfg_pol` = 1 makes a high-to-low transition an event. The transition of the other direction is no event. `tamper_flag` is high within four clock cycles of the pin change.
- R2: With `cfg_filt` nonzero (level mode), `cfg_pol` = 0 makes a low pin level the active level and `cfg_pol` = 1 makes a high pin level the active level.
- R3: While the stored enable bit is 0, neither edges nor levels on the pin set `tamper_flag`.
- R4: `irq` equals `tamper_flag` AND the stored interrupt enable, one cycle after each write.
- R5: When the stored `cfg_ts_force` is 1, each tamper event produces exactly one single-cycle `ts_pulse` high in the cycle the flag is set. When it is 0, tamper events never raise `ts_pulse`.
- R6: `cfg_we` high at a clock edge loads `cfg_en`, `cfg_pol`, `cfg_filt`, `cfg_ie` and `cfg_ts_force` together. After reset all stored fields are 0, and `tamper_flag`, `irq` and `ts_pulse` are 0.
- R7: In level mode an event needs 2, 4 or 8 consecutive `smp_tick` samples at the active level, for `cfg_filt` = 1, 2 or 3. A sample at the other level restarts the count. An unbroken active level gives only one event.
- R8: An edge-mode event needs the enable bit set in both the current and the previous cycle. The level-mode sample count is held at zero while disabled. Setting the enable bit while the pin already sits at any level causes no event.
- R9: `tamper_flag` stays set until a write with `flag_we` = 1 and `flag_wdata` = 0 clears it. Writing 1 has no effect. An event in the same cycle as a clearing write leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tamper_pin | input | 1 | External tamper input, asynchronous |
| smp_tick | input | 1 | Sample strobe for level-mode filtering, one cycle wide |
| cfg_we | input | 1 | Loads all configuration fields |
| cfg_en | input | 1 | Detection enable |
| cfg_pol | input | 1 | Trigger polarity (edge direction or active level) |
| cfg_filt | input | 2 | Filter setting: 0 edge mode, 1..3 level mode with 2/4/8 samples |
| cfg_ie | input | 1 | Interrupt enable |
| cfg_ts_force | input | 1 | Tamper also sets the timestamp flag |
| flag_we | input | 1 | Tamper flag write strobe |
| flag_wdata | input | 1 | Value written to the tamper flag; only 0 acts |
| tamper_flag | output | 1 | Latched tamper flag |
| irq | output | 1 | Interrupt request |
| ts_pulse | output | 1 | One-cycle pulse that sets the timestamp flag |

## Verification
The properties assume that polarity and filter settings change only in a write that also clears the enable bit, and that re-enabling is a separate write. This is what makes back-to-back timestamp pulses and events at re-arm impossible. The random stimulus follows this rule: it rewrites the whole configuration with the enable bit low, then sets the enable bit one cycle later with the other fields unchanged. Interrupt enable and the timestamp option may change at any time. Pin toggles, sample strobes and flag writes are otherwise free, and clear writes collide with events often enough to exercise the set-wins rule.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
  localparam int TMP_FILT_W = 2;

  typedef struct packed {
    logic                  en;
    logic                  pol;
    logic [TMP_FILT_W-1:0] filt;
    logic                  ie;
    logic                  ts_force;
  } tamper_cfg_t;
endpackage

// File: rtl/tamper_rst_sync.sv
module tamper_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/tamper_pin_sync.sv
module tamper_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/tamper_lvl_filter.sv
module tamper_lvl_filter #(
  parameter int FILT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick,
  input  logic              match,
  input  logic [FILT_W-1:0] filt,
  output logic              fire
);
  localparam int MAX_EXP = (1 << FILT_W) - 1;
  localparam int CNT_W   = MAX_EXP + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] target;
  logic             cnt_en;

  assign target = CNT_W'(1) << filt;
  assign cnt_en = clr | tick;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (tick) begin
      if (!match)               cnt_d = '0;
      else if (cnt_q != target) cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign fire = !clr && tick && match && (cnt_q == target - CNT_W'(1));
endmodule

// File: rtl/tamper_detect_top.sv
module tamper_detect_top
  import tamper_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tamper_pin,
  input  logic                  smp_tick,
  input  logic                  cfg_we,
  input  logic                  cfg_en,
  input  logic                  cfg_pol,
  input  logic [TMP_FILT_W-1:0] cfg_filt,
  input  logic                  cfg_ie,
  input  logic                  cfg_ts_force,
  input  logic                  flag_we,
  input  logic                  flag_wdata,
  output logic                  tamper_flag,
  output logic                  irq,
  output logic                  ts_pulse
);
  logic        rst_sync_n;
  logic        pin_s;
  tamper_cfg_t cfg_q, cfg_d;
  logic        en_q, en_d_q, en_d_d;
  logic        prev_q, prev_d;
  logic        flag_q, flag_d;
  logic        ts_q, ts_d;
  logic        lvl_mode, match, edge_hit, evt_edge, lvl_clr, lvl_fire, evt;

  tamper_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_sync(rst_sync_n)
  );

  tamper_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .din(tamper_pin), .dout(pin_s)
  );

  assign en_q     = cfg_q.en;
  assign lvl_mode = |cfg_q.filt;
  assign match    = (pin_s == cfg_q.pol);
  assign edge_hit = cfg_q.pol ? (prev_q & ~pin_s) : (pin_s & ~prev_q);
  assign evt_edge = en_q & en_d_q & ~lvl_mode & edge_hit;
  assign lvl_clr  = ~en_q | ~lvl_mode;

  tamper_lvl_filter #(.FILT_W(TMP_FILT_W)) u_filt (
    .clk(clk), .rst_n(rst_sync_n), .clr(lvl_clr), .tick(smp_tick),
    .match(match), .filt(cfg_q.filt), .fire(lvl_fire)
  );

  assign evt = evt_edge | lvl_fire;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) begin
      cfg_d.en       = cfg_en;
      cfg_d.pol      = cfg_pol;
      cfg_d.filt     = cfg_filt;
      cfg_d.ie       = cfg_ie;
      cfg_d.ts_force = cfg_ts_force;
    end
    en_d_d = en_q;
    prev_d = pin_s;
    flag_d = flag_q;
    if (flag_we && !flag_wdata) flag_d = 1'b0;
    if (evt)                    flag_d = 1'b1;
    ts_d = evt & cfg_q.ts_force;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cfg_q  <= '0;
      en_d_q <= 1'b0;
      prev_q <= 1'b0;
      flag_q <= 1'b0;
      ts_q   <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= cfg_d;
      en_d_q <= en_d_d;
      prev_q <= prev_d;
      flag_q <= flag_d;
      ts_q   <= ts_d;
    end
  end

  assign tamper_flag = flag_q;
  assign irq         = flag_q & cfg_q.ie;
  assign ts_pulse    = ts_q;
endmodule

// File: rtl/tamper_detect_chk.sv
module tamper_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic en_q,
  input logic en_d,
  input logic lvl_mode,
  input logic smp_tick,
  input logic flag_we,
  input logic flag_wdata,
  input logic tamper_flag,
  input logic irq,
  input logic ts_pulse
);
  AST_NO_EVT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !$rose(tamper_flag)); // R3
  AST_REARM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !en_d && !lvl_mode) |=> !$rose(tamper_flag)); // R8
  AST_LVL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && lvl_mode && !smp_tick) |=> !$rose(tamper_flag)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tamper_flag && !(flag_we && !flag_wdata)) |=> tamper_flag); // R9
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> tamper_flag); // R4
  AST_TS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ts_pulse |=> !ts_pulse); // R5
  AST_TS_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    ts_pulse |-> tamper_flag); // R5
endmodule

bind tamper_detect_top tamper_detect_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .en_q(en_q), .en_d(en_d_q),
  .lvl_mode(lvl_mode), .smp_tick(smp_tick), .flag_we(flag_we),
  .flag_wdata(flag_wdata), .tamper_flag(tamper_flag), .irq(irq),
  .ts_pulse(ts_pulse)
);

// File: tb/tb_tamper_detect_top.sv
module tb_tamper_detect_top;
  localparam time CLK_P = 8ns;

  logic       clk = 1'b0;
  logic       rst_n, tamper_pin, smp_tick, cfg_we, cfg_en, cfg_pol;
  logic [1:0] cfg_filt;
  logic       cfg_ie, cfg_ts_force, flag_we, flag_wdata;
  logic       tamper_flag, irq, ts_pulse;

  int n_chk = 0, n_fail = 0, ts_seen = 0;
  bit done = 0;
  bit m_on = 0;

  always #(CLK_P/2) clk = ~clk;

  tamper_detect_top dut (
    .clk(clk), .rst_n(rst_n), .tamper_pin(tamper_pin), .smp_tick(smp_tick),
    .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_pol(cfg_pol), .cfg_filt(cfg_filt),
    .cfg_ie(cfg_ie), .cfg_ts_force(cfg_ts_force), .flag_we(flag_we),
    .flag_wdata(flag_wdata), .tamper_flag(tamper_flag), .irq(irq),
    .ts_pulse(ts_pulse)
  );

  always @(negedge clk) if (ts_pulse) ts_seen++;

  // Requirement-level model: pin synchroniser, config, edge/level events, flag.
  logic m_s1, m_s2, m_prev, m_en, m_end, m_pol, m_ie, m_tsf, m_flag, m_ts, m_ev;
  logic [1:0] m_filt;
  logic [3:0] m_cnt, m_tgt;

  function automatic logic edge_ev(logic pol, logic prev, logic cur);
    return pol ? (prev & ~cur) : (cur & ~prev);
  endfunction

  always @(posedge clk) begin
    if (cfg_we) begin
      m_en <= cfg_en; m_pol <= cfg_pol; m_filt <= cfg_filt;
      m_ie <= cfg_ie; m_tsf <= cfg_ts_force;
    end
    if (!m_on) begin
      m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_end <= 0;
      m_cnt <= 0; m_flag <= 0; m_ts <= 0;
    end else begin
      m_tgt = 4'd1 << m_filt;
      if (m_filt == 0) m_ev = m_en && m_end && edge_ev(m_pol, m_prev, m_s2);
      else m_ev = m_en && smp_tick && (m_s2 == m_pol) && (m_cnt == m_tgt - 1);
      if (!m_en || m_filt == 0) m_cnt <= 0;
      else if (smp_tick) m_cnt <= (m_s2 != m_pol) ? 4'd0 : (m_cnt != m_tgt ? m_cnt + 1 : m_cnt);
      m_s1 <= tamper_pin; m_s2 <= m_s1; m_prev <= m_s2; m_end <= m_en;
      if (m_ev) m_flag <= 1;
      else if (flag_we && !flag_wdata) m_flag <= 0;
      m_ts <= m_ev & m_tsf;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_int(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wcfg(logic en, logic pol, logic [1:0] filt, logic ie, logic tsf);
    @(negedge clk);
    cfg_we = 1; cfg_en = en; cfg_pol = pol; cfg_filt = filt; cfg_ie = ie; cfg_ts_force = tsf;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic wflag(logic v);
    @(negedge clk); flag_we = 1; flag_wdata = v;
    @(negedge clk); flag_we = 0;
  endtask

  task automatic ticks(int n);
    repeat (n) begin
      @(negedge clk); smp_tick = 1;
      @(negedge clk); smp_tick = 0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int t0;
    void'($urandom(32'd4711));
    rst_n = 0; tamper_pin = 0; smp_tick = 0; cfg_we = 0; cfg_en = 0; cfg_pol = 0;
    cfg_filt = 0; cfg_ie = 0; cfg_ts_force = 0; flag_we = 0; flag_wdata = 0;
    cyc(3);
    chk("R6 reset flag", tamper_flag, 0);
    chk("R6 reset irq", irq, 0);
    chk("R6 reset ts", ts_pulse, 0);
    rst_n = 1; cyc(4);

    // R1 rising edge, polarity 0
    wcfg(0, 0, 0, 1, 1); wcfg(1, 0, 0, 1, 1); cyc(3);
    t0 = ts_seen;
    tamper_pin = 1; cyc(4);
    chk("R1 rising edge sets flag", tamper_flag, 1);
    chk("R4 irq with ie=1", irq, 1);
    chk_int("R5 one ts pulse", ts_seen - t0, 1);
    wflag(1); chk("R9 write 1 no effect", tamper_flag, 1);
    wflag(0); chk("R9 write 0 clears", tamper_flag, 0);
    tamper_pin = 0; cyc(4);
    chk("R1 falling ignored with pol 0", tamper_flag, 0);

    // R1 falling edge, polarity 1, no irq, no ts
    wcfg(0, 1, 0, 0, 0); wcfg(1, 1, 0, 0, 0); cyc(2);
    t0 = ts_seen;
    tamper_pin = 1; cyc(4);
    chk("R1 rising ignored with pol 1", tamper_flag, 0);
    tamper_pin = 0; cyc(4);
    chk("R1 falling edge sets flag", tamper_flag, 1);
    chk("R4 irq masked", irq, 0);
    chk_int("R5 no ts when option off", ts_seen - t0, 0);
    wcfg(1, 1, 0, 1, 0);
    chk("R4 irq follows ie write", irq, 1);
    wflag(0);

    // R3 disabled
    wcfg(0, 0, 0, 1, 1);
    tamper_pin = 1; cyc(4); tamper_pin = 0; cyc(4); tamper_pin = 1; cyc(4);
    chk("R3 edges ignored when disabled", tamper_flag, 0);
    wcfg(0, 1, 1, 1, 1); ticks(4);
    chk("R3 level ignored when disabled", tamper_flag, 0);

    // R8 enable while pin already high in edge mode
    wcfg(0, 0, 0, 1, 1); cyc(3);
    wcfg(1, 0, 0, 1, 1); cyc(6);
    chk("R8 no event on re-enable", tamper_flag, 0);

    // R2/R7 level high, 2 samples
    wcfg(0, 1, 1, 1, 1); wcfg(1, 1, 1, 1, 1);
    t0 = ts_seen;
    ticks(1); chk("R7 one sample not enough", tamper_flag, 0);
    ticks(1); chk("R2 high level with pol 1", tamper_flag, 1);
    wflag(0); ticks(5);
    chk("R7 one event per level", tamper_flag, 0);
    chk_int("R7 single ts pulse", ts_seen - t0, 1);

    // R2/R7 level low, 8 samples with restart
    wcfg(0, 0, 3, 1, 0); tamper_pin = 0; cyc(4); wcfg(1, 0, 3, 1, 0);
    ticks(5); tamper_pin = 1; cyc(4); ticks(1); tamper_pin = 0; cyc(4);
    ticks(7); chk("R7 restart after mismatch", tamper_flag, 0);
    ticks(1); chk("R2 low level with pol 0, 8 samples", tamper_flag, 1);
    wflag(0);
    wcfg(0, 0, 2, 1, 0); wcfg(1, 0, 2, 1, 0);
    ticks(3); chk("R7 3 of 4 samples", tamper_flag, 0);
    ticks(1); chk("R7 4 samples", tamper_flag, 1);

    // Random phase against the model
    wcfg(0, 0, 0, 0, 0); tamper_pin = 0; cyc(4); wflag(0); cyc(2);
    m_on = 1;
    begin
      logic pol, ie, tsf; logic [1:0] filt;
      pol = 0; filt = 0; ie = 0; tsf = 0;
      for (int i = 0; i < 4000; i++) begin
        @(negedge clk);
        if (i > 0) begin
          chk("R1 R2 R9 flag vs model", tamper_flag, m_flag);
          chk("R4 irq vs model", irq, m_flag & m_ie);
          chk("R5 ts vs model", ts_pulse, m_ts);
        end
        cfg_we = 0;
        if (i % 250 == 0) begin
          pol = 1'($urandom); filt = 2'($urandom); ie = 1'($urandom); tsf = 1'($urandom);
          cfg_we = 1; cfg_en = 0; cfg_pol = pol; cfg_filt = filt; cfg_ie = ie; cfg_ts_force = tsf;
        end else if (i % 250 == 1) begin
          cfg_we = 1; cfg_en = 1;
        end
        if ($urandom % 100 < ((filt == 0) ? 20 : 4)) tamper_pin = ~tamper_pin;
        smp_tick = ($urandom % 3 == 0);
        flag_we = ($urandom % 12 == 0);
        flag_wdata = 1'($urandom);
      end
    end
    finish_run();
  end
endmodule